// File: doc/BRIEF.md
# Standby Clock Controller

This block decides whether the core pipeline receives its clock enable. When the core signals that it has executed a wait instruction, the controller moves into a low-power standby mode and drops the pipeline clock enable, so the pipeline holds its state. While in standby, a free-running timer keeps counting. Every monitored input also stays sampled: six interrupt lines, a non-maskable interrupt, an external request and two reset requests.

Any interrupt brings the controller back to run mode. That includes a timer compare interrupt raised inside the block. On the way out, the controller raises the clock enable again and sends the core a single-cycle wake pulse. Either reset request forces the clock enable on without delay, whatever the mode. External pins pass through a parameterised synchroniser before they can wake the core. The timer interrupt is internal and does not need one.

All ports are plain control and status signals. No data is streamed, so there is no valid/ready handshake and no back-pressure.

Top module: `standby_clk_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it is released, the outputs are `pipe_ce`=1, `in_standby`=0, `wake_pulse`=0, `tmr_irq`=0 and `tmr_count`=0.
- R2: A high `wait_req` at a rising edge, with no interrupt pending and both reset requests high, puts the controller in standby from that edge on. In standby, `pipe_ce` is 0 unless a reset request is low.
- R3: `tmr_count` increases by one on every rising edge in both modes and wraps modulo 2^TMR_W.
- R4: The interrupt lines `irq_n[i]` and `nmi_n` are active low. The first rising edge that sees such a line low is edge 1. In standby, `pipe_ce` returns to 1 right after edge SYNC_STAGES+1, and the controller leaves standby at that edge.
- R5: With `tmr_en`=1, `tmr_irq` is set by the edge after the one that makes `tmr_count` equal `tmr_cmp`. A set `tmr_irq` wakes the controller at the next edge. `tmr_ack`=1 clears it, but a compare hit in the same cycle wins. With `tmr_en`=0 the timer never interrupts.
- R6: `wake_pulse` is 1 for exactly the first run cycle after a wake from an interrupt and 0 at all other times.
- R7: When `warm_rst_n` or `cold_rst_n` is low, `pipe_ce` is 1 at once, the controller is in run mode after the next edge, and no `wake_pulse` is produced. `wait_req` has no effect while either reset request is low.
- R8: A `wait_req` that arrives while any synchronised interrupt or the timer interrupt is pending leaves the controller in run mode.
- R9: `ext_req_n` is active low. `ext_req_seen` shows its inverted value, delayed by SYNC_STAGES edges. The external request never wakes the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wait_req | input | 1 | Core executed a wait instruction |
| irq_n | input | NUM_IRQ | Active-low interrupt lines |
| nmi_n | input | 1 | Active-low non-maskable interrupt |
| ext_req_n | input | 1 | Active-low external request |
| warm_rst_n | input | 1 | Active-low warm reset request |
| cold_rst_n | input | 1 | Active-low cold reset request |
| tmr_en | input | 1 | Timer compare interrupt enable |
| tmr_cmp | input | TMR_W | Timer compare value |
| tmr_ack | input | 1 | Clears the timer interrupt flag |
| pipe_ce | output | 1 | Pipeline clock enable |
| in_standby | output | 1 | Controller is in standby mode |
| wake_pulse | output | 1 | One-cycle wake indication to the core |
| tmr_count | output | TMR_W | Free-running timer value |
| tmr_irq | output | 1 | Timer compare interrupt pending |
| ext_req_seen | output | 1 | Synchronised external request, active high |

## Verification
Several cases are provoked on purpose:
- A wait request made while an interrupt is already pending. The bench first holds an interrupt low until it has passed the synchroniser, then pulses `wait_req`. The clock enable must stay high.
- A reset request in the same cycle as an interrupt wake. The bench drops a reset request and an interrupt line together while in standby. Over the whole wake window, `wake_pulse` must never rise, and `pipe_ce` must read high straight away.
- A timer acknowledge in the same cycle as a compare hit. The set must win.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic {
    MODE_RUN     = 1'b0,
    MODE_STANDBY = 1'b1
  } sbc_mode_e;

  localparam int unsigned SBC_NUM_IRQ_DEF = 6;
  localparam int unsigned SBC_TMR_W_DEF   = 8;
  localparam int unsigned SBC_SYNC_DEF    = 2;

endpackage

// File: rtl/sbc_sync_bank.sv
module sbc_sync_bank #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RST_VAL;
        else        stage_q <= d_in[b];
      end
      assign q_out[b] = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_in[b]};
      end
      assign q_out[b] = chain_q[STAGES-1];
    end
  end

endmodule

// File: rtl/sbc_timer.sv
module sbc_timer #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic [TMR_W-1:0] tmr_cmp,
  input  logic             tmr_ack,
  output logic [TMR_W-1:0] count_q,
  output logic             irq_q
);

  logic hit;

  assign hit = tmr_en && (count_q == tmr_cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (hit)     irq_q <= 1'b1;
    else if (tmr_ack) irq_q <= 1'b0;
  end

endmodule

// File: rtl/sbc_mode_fsm.sv
module sbc_mode_fsm
  import sbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic pend_any,
  input  logic force_run,
  output logic in_standby,
  output logic wake_pulse
);

  sbc_mode_e mode_q, mode_d;
  logic      wake_d;

  always_comb begin
    mode_d = mode_q;
    wake_d = 1'b0;
    if (force_run) begin
      mode_d = MODE_RUN;
    end else begin
      unique case (mode_q)
        MODE_RUN: begin
          if (wait_req && !pend_any) mode_d = MODE_STANDBY;
        end
        MODE_STANDBY: begin
          if (pend_any) begin
            mode_d = MODE_RUN;
            wake_d = 1'b1;
          end
        end
        default: mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_RUN;
      wake_pulse <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      wake_pulse <= wake_d;
    end
  end

  assign in_standby = (mode_q == MODE_STANDBY);

endmodule

// File: rtl/standby_clk_ctrl.sv
module standby_clk_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = SBC_NUM_IRQ_DEF,
  parameter int unsigned TMR_W       = SBC_TMR_W_DEF,
  parameter int unsigned SYNC_STAGES = SBC_SYNC_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wait_req,
  input  logic [NUM_IRQ-1:0] irq_n,
  input  logic               nmi_n,
  input  logic               ext_req_n,
  input  logic               warm_rst_n,
  input  logic               cold_rst_n,
  input  logic               tmr_en,
  input  logic [TMR_W-1:0]   tmr_cmp,
  input  logic               tmr_ack,
  output logic               pipe_ce,
  output logic               in_standby,
  output logic               wake_pulse,
  output logic [TMR_W-1:0]   tmr_count,
  output logic               tmr_irq,
  output logic               ext_req_seen
);

  localparam int unsigned PIN_W = NUM_IRQ + 2;

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_sync;
  logic             force_run;
  logic             pin_irq_any;
  logic             pend_any;

  // bit layout: irq lines low, then nmi, then external request on top
  assign pins_raw = {ext_req_n, nmi_n, irq_n};

  sbc_sync_bank #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pins_raw),
    .q_out (pins_sync)
  );

  sbc_timer #(
    .TMR_W (TMR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_en  (tmr_en),
    .tmr_cmp (tmr_cmp),
    .tmr_ack (tmr_ack),
    .count_q (tmr_count),
    .irq_q   (tmr_irq)
  );

  assign force_run   = !warm_rst_n || !cold_rst_n;
  assign pin_irq_any = !(&pins_sync[NUM_IRQ:0]);
  assign pend_any    = pin_irq_any || tmr_irq;

  sbc_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_req   (wait_req),
    .pend_any   (pend_any),
    .force_run  (force_run),
    .in_standby (in_standby),
    .wake_pulse (wake_pulse)
  );

  assign pipe_ce      = !in_standby || force_run;
  assign ext_req_seen = !pins_sync[PIN_W-1];

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int unsigned TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_req,
  input logic             warm_rst_n,
  input logic             cold_rst_n,
  input logic             pend_any,
  input logic             pipe_ce,
  input logic             in_standby,
  input logic             wake_pulse,
  input logic [TMR_W-1:0] tmr_count
);

  p_wait_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !in_standby && !pend_any && warm_rst_n && cold_rst_n) |=> in_standby);

  p_standby_no_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_standby && warm_rst_n && cold_rst_n) |-> !pipe_ce);

  p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tmr_count == TMR_W'($past(tmr_count) + 1'b1)));

  p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  p_wake_from_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pulse) |-> ($past(in_standby) && !in_standby && pipe_ce));

  p_reset_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst_n || !cold_rst_n) |-> pipe_ce);

  p_reset_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst_n || !cold_rst_n) |=> (!in_standby && !wake_pulse));

  p_pending_blocks_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && pend_any && !in_standby) |=> !in_standby);

endmodule

bind standby_clk_ctrl sbc_checker #(.TMR_W(TMR_W)) u_sbc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wait_req   (wait_req),
  .warm_rst_n (warm_rst_n),
  .cold_rst_n (cold_rst_n),
  .pend_any   (pend_any),
  .pipe_ce    (pipe_ce),
  .in_standby (in_standby),
  .wake_pulse (wake_pulse),
  .tmr_count  (tmr_count)
);

// File: tb/standby_clk_ctrl_bench.sv
module standby_clk_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ    = 6;
  localparam int TMR_W      = 8;
  localparam int SYNC       = 2;
  localparam int LAT        = SYNC + 1;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wait_req;
  logic [NUM_IRQ-1:0] irq_n;
  logic               nmi_n, ext_req_n, warm_rst_n, cold_rst_n;
  logic               tmr_en, tmr_ack;
  logic [TMR_W-1:0]   tmr_cmp;
  logic               pipe_ce, in_standby, wake_pulse, tmr_irq, ext_req_seen;
  logic [TMR_W-1:0]   tmr_count;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_clk_ctrl #(.NUM_IRQ(NUM_IRQ), .TMR_W(TMR_W), .SYNC_STAGES(SYNC)) u_standby_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .irq_n(irq_n), .nmi_n(nmi_n),
    .ext_req_n(ext_req_n), .warm_rst_n(warm_rst_n), .cold_rst_n(cold_rst_n),
    .tmr_en(tmr_en), .tmr_cmp(tmr_cmp), .tmr_ack(tmr_ack), .pipe_ce(pipe_ce),
    .in_standby(in_standby), .wake_pulse(wake_pulse), .tmr_count(tmr_count),
    .tmr_irq(tmr_irq), .ext_req_seen(ext_req_seen)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic enter_standby();
    wait_req = 1'b1;
    @(negedge clk);
    wait_req = 1'b0;
    chk("R2 in_standby", in_standby, 1);
    chk("R2 pipe_ce", pipe_ce, 0);
  endtask

  task automatic settle();
    repeat (LAT + 1) @(negedge clk);
  endtask

  // sel < NUM_IRQ: irq line sel; sel == NUM_IRQ: nmi; sel > NUM_IRQ: all lines
  task automatic wake_by(input int sel);
    if (sel < NUM_IRQ) irq_n[sel] = 1'b0;
    else if (sel == NUM_IRQ) nmi_n = 1'b0;
    else begin irq_n = '0; nmi_n = 1'b0; end
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k < LAT) chk("R4 ce held low during sync", pipe_ce, 0);
      else begin
        chk("R4 ce back after latency", pipe_ce, 1);
        chk("R6 wake pulse raised", wake_pulse, 1);
      end
    end
    @(negedge clk);
    chk("R6 wake pulse one cycle", wake_pulse, 0);
    chk("R4 stays in run", in_standby, 0);
    irq_n = '1; nmi_n = 1'b1;
    settle();
  endtask

  initial begin
    int c0;
    bit saw_wake;
    rst_n = 1'b0; wait_req = 1'b0; irq_n = '1; nmi_n = 1'b1; ext_req_n = 1'b1;
    warm_rst_n = 1'b1; cold_rst_n = 1'b1; tmr_en = 1'b0; tmr_ack = 1'b0; tmr_cmp = '0;
    repeat (3) @(negedge clk);
    chk("R1 ce in reset", pipe_ce, 1);
    rst_n = 1'b1;
    chk("R1 ce", pipe_ce, 1);
    chk("R1 standby", in_standby, 0);
    chk("R1 wake", wake_pulse, 0);
    chk("R1 count", tmr_count, 0);
    chk("R1 tmr_irq", tmr_irq, 0);

    // R4/R6: sweep every interrupt source, then all at once
    for (int s = 0; s <= NUM_IRQ + 1; s++) begin
      enter_standby();
      wake_by(s);
    end

    // R3: timer runs in standby and wraps; tmr_en=0 never wakes (R5)
    enter_standby();
    c0 = int'(tmr_count);
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      chk("R3 timer step", tmr_count, (c0 + k) % (1 << TMR_W));
      chk("R5 disabled timer no wake", in_standby, 1);
    end

    // R5: timer compare wakes the controller
    tmr_cmp = TMR_W'(tmr_count + 6);
    tmr_en  = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 6) chk("R5 flag not yet", tmr_irq, 0);
      if (k == 7) begin
        chk("R5 flag set", tmr_irq, 1);
        chk("R5 ce still low", pipe_ce, 0);
      end
      if (k == 8) begin
        chk("R5 timer wake ce", pipe_ce, 1);
        chk("R5 timer wake pulse", wake_pulse, 1);
      end
    end
    tmr_en = 1'b0; tmr_ack = 1'b1;
    @(negedge clk);
    tmr_ack = 1'b0;
    chk("R5 ack clears", tmr_irq, 0);
    // R5: ack in same cycle as hit, set wins
    tmr_cmp = TMR_W'(tmr_count + 2);
    tmr_en = 1'b1;
    @(negedge clk); @(negedge clk);
    tmr_ack = 1'b1;
    @(negedge clk);
    tmr_ack = 1'b0; tmr_en = 1'b0;
    chk("R5 set wins over ack", tmr_irq, 1);
    // R8: wait while timer flag pending stays in run
    wait_req = 1'b1;
    @(negedge clk);
    wait_req = 1'b0;
    chk("R8 timer pending blocks wait", in_standby, 0);
    tmr_ack = 1'b1;
    @(negedge clk);
    tmr_ack = 1'b0;
    chk("R5 ack clears again", tmr_irq, 0);

    // R8: pending pin interrupt blocks entry
    irq_n[2] = 1'b0;
    repeat (SYNC) @(negedge clk);
    wait_req = 1'b1;
    @(negedge clk);
    wait_req = 1'b0;
    chk("R8 no standby with pending", in_standby, 0);
    chk("R8 ce kept", pipe_ce, 1);
    irq_n = '1;
    settle();

    // R9: external request is sampled but does not wake
    enter_standby();
    ext_req_n = 1'b0;
    for (int k = 1; k <= SYNC + 4; k++) begin
      @(negedge clk);
      chk("R9 seen timing", ext_req_seen, (k >= SYNC) ? 1 : 0);
      chk("R9 no wake", pipe_ce, 0);
    end
    ext_req_n = 1'b1;
    repeat (SYNC) @(negedge clk);
    chk("R9 seen clears", ext_req_seen, 0);

    // R7: warm then cold reset request from standby
    for (int r = 0; r < 2; r++) begin
      if (r == 0) warm_rst_n = 1'b0; else cold_rst_n = 1'b0;
      #1;
      chk("R7 ce immediate", pipe_ce, 1);
      @(negedge clk);
      chk("R7 run after edge", in_standby, 0);
      chk("R7 no wake pulse", wake_pulse, 0);
      wait_req = 1'b1;
      @(negedge clk);
      wait_req = 1'b0;
      chk("R7 wait ignored in reset", in_standby, 0);
      warm_rst_n = 1'b1; cold_rst_n = 1'b1;
      @(negedge clk);
      enter_standby();
    end

    // R7 vs R6: reset request and interrupt in the same cycle
    cold_rst_n = 1'b0;
    irq_n[5] = 1'b0;
    #1;
    chk("R7 ce immediate with irq", pipe_ce, 1);
    saw_wake = 0;
    for (int k = 1; k <= LAT + 2; k++) begin
      @(negedge clk);
      if (wake_pulse) saw_wake = 1;
    end
    chk("R7 reset suppresses wake pulse", saw_wake, 0);
    chk("R7 ended in run", in_standby, 0);
    cold_rst_n = 1'b1; irq_n = '1;
    settle();

    // R2: normal entry still works afterwards
    enter_standby();
    wake_by(0);

    finish_run();
  end

endmodule